// File: doc/BRIEF.md
# Predicate Register Bank with Parallel Compare Writes

This block holds the one-bit predicate registers that gate conditional execution, together with the write logic that retires one group of compare operations per clock. Every compare lane delivers a ready-made boolean condition, two destination predicate indices, a compare kind and a flag that marks a source carrying a deferred fault. Each lane is also gated by a qualifying predicate, which is read from the bank as it stood before the group.

Three compare kinds are supported. A normal compare writes the condition to one destination and its inverse to the other. The "and" kind can only clear its destinations, and the "or" kind can only set them. Because the and and or kinds write in one direction only, many lanes may target the same predicate in one group and the result is still well defined. Predicate 0 always reads as true. Read ports return qualifying predicates for downstream instructions.

All lanes of a group are applied together at one clock edge. When two normal-kind writes land on the same predicate in the same group, a registered error flag is raised.

Top module: `pred_file`

## Requirements
- R1: After reset every predicate reads 0 except predicate 0, which reads 1 at all times; the conflict flag is 0 after reset.
- R2: A qualified normal compare (kind code 0) writes the condition to its first destination and the inverted condition to its second; the new values are visible on the read ports after the next rising clock edge.
- R3: A lane whose qualifying predicate reads 0 is squashed and changes no predicate, whatever its kind, condition or tag.
- R4: A qualified and-kind compare (kind code 1) clears both destinations when its condition is 0 and leaves them unchanged when it is 1, so after a group a predicate targeted only by and-kind lanes equals its prior value ANDed with every condition.
- R5: A qualified or-kind compare (kind code 2) sets both destinations when its condition is 1 and leaves them unchanged when it is 0.
- R6: A qualified compare whose source-tag flag is 1 writes 0 to both destinations, whatever its kind (0, 1 or 2) and condition.
- R7: A write aimed at predicate 0 has no effect; predicate 0 still reads 1.
- R8: All lanes of one group are applied at the same edge: qualifying predicates are taken from the state before the group, and when one group both sets and clears a predicate, the clear wins.
- R9: Two or more normal-kind writes to the same nonzero predicate in one group (including one lane naming the same predicate twice) raise `conflict_err` for exactly the cycle after that edge; the writes are still merged with clear winning.
- R10: Each read port returns the current value of the predicate it indexes, combinationally, and kind code 3 makes a lane write nothing even when tagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_vld | input | 4 | Per-lane valid |
| cmp_qp | input | 24 | Per-lane qualifying predicate index, 6 bits per lane |
| cmp_dst_a | input | 24 | Per-lane first destination index |
| cmp_dst_b | input | 24 | Per-lane second destination index |
| cmp_kind | input | 8 | Per-lane compare kind, 2 bits per lane: 0 normal, 1 and, 2 or, 3 none |
| cmp_cond | input | 4 | Per-lane condition result |
| cmp_tag | input | 4 | Per-lane deferred-fault source flag |
| rd_idx | input | 12 | Read port indices, 6 bits per port |
| rd_val | output | 2 | Read port predicate values |
| conflict_err | output | 1 | Conflicting normal-kind writes occurred in the previous group |

## Verification
A corrupted predicate bit shows up on a read port as soon as that index is selected, one edge after the faulty group, and it also shows a cycle later as a wrongly squashed or wrongly enabled lane that names it as qualifier. A wrong merge, such as set winning over clear or a qualifier read after the update, leaves a bit wrong that the full sweep of both read ports after every group exposes. The bench compares all 64 predicates after each group and the conflict flag in the cycle following each group, so a fault is caught no later than one group after it occurs.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic [1:0] {
        CK_NORM = 2'd0,
        CK_AND  = 2'd1,
        CK_OR   = 2'd2,
        CK_NONE = 2'd3
    } cmp_kind_e;

endpackage

// File: rtl/pred_cmp_lane.sv
// One compare lane: turns a retired compare into set / clear masks over
// the predicate bank, plus masks of normal-kind targets for clash detection.
module pred_cmp_lane
    import pred_pkg::*;
#(
    parameter int NUM_PREDS = 64,
    parameter int IDX_W     = $clog2(NUM_PREDS)
) (
    input  logic                 vld,
    input  logic                 qp_true,
    input  logic [IDX_W-1:0]     dst_a,
    input  logic [IDX_W-1:0]     dst_b,
    input  logic [1:0]           kind,
    input  logic                 cond,
    input  logic                 tag,
    output logic [NUM_PREDS-1:0] set_m,
    output logic [NUM_PREDS-1:0] clr_m,
    output logic [NUM_PREDS-1:0] norm_a_m,
    output logic [NUM_PREDS-1:0] norm_b_m
);

    typedef struct packed {
        logic en_a;
        logic en_b;
        logic val_a;
        logic val_b;
    } wr_t;

    cmp_kind_e            kind_e;
    logic                 live;
    logic [NUM_PREDS-1:0] oh_a;
    logic [NUM_PREDS-1:0] oh_b;
    wr_t                  wr;

    assign kind_e = cmp_kind_e'(kind);
    assign live   = vld && qp_true && (kind_e != CK_NONE);

    // destination decode; predicate 0 is never a write target (R7)
    always_comb begin
        oh_a        = '0;
        oh_b        = '0;
        oh_a[dst_a] = 1'b1;
        oh_b[dst_b] = 1'b1;
        oh_a[0]     = 1'b0;
        oh_b[0]     = 1'b0;
    end

    always_comb begin
        wr = '0;
        if (live) begin
            if (tag) begin
                // deferred-fault source: both destinations forced false (R6)
                wr = '{en_a: 1'b1, en_b: 1'b1, val_a: 1'b0, val_b: 1'b0};
            end else begin
                unique case (kind_e)
                    CK_NORM: wr = '{en_a: 1'b1, en_b: 1'b1, val_a: cond, val_b: !cond};
                    CK_AND:  wr = '{en_a: !cond, en_b: !cond, val_a: 1'b0, val_b: 1'b0};
                    CK_OR:   wr = '{en_a: cond, en_b: cond, val_a: 1'b1, val_b: 1'b1};
                    default: wr = '0;
                endcase
            end
        end
    end

    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (wr.en_a) begin
            if (wr.val_a) set_m = set_m | oh_a;
            else          clr_m = clr_m | oh_a;
        end
        if (wr.en_b) begin
            if (wr.val_b) set_m = set_m | oh_b;
            else          clr_m = clr_m | oh_b;
        end
    end

    always_comb begin
        norm_a_m = '0;
        norm_b_m = '0;
        if (live && kind_e == CK_NORM) begin
            norm_a_m = oh_a;
            norm_b_m = oh_b;
        end
    end

endmodule

// File: rtl/pred_merge.sv
// Combines the masks of all lanes of one group and finds predicates that
// received more than one normal-kind write.
module pred_merge #(
    parameter int NUM_CMP   = 4,
    parameter int NUM_PREDS = 64
) (
    input  logic [NUM_CMP-1:0][NUM_PREDS-1:0] set_all,
    input  logic [NUM_CMP-1:0][NUM_PREDS-1:0] clr_all,
    input  logic [NUM_CMP-1:0][NUM_PREDS-1:0] norm_a_all,
    input  logic [NUM_CMP-1:0][NUM_PREDS-1:0] norm_b_all,
    output logic [NUM_PREDS-1:0]              set_m,
    output logic [NUM_PREDS-1:0]              clr_m,
    output logic                              clash
);

    logic [NUM_PREDS-1:0] seen;
    logic [NUM_PREDS-1:0] dup;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        seen  = '0;
        dup   = '0;
        for (int l = 0; l < NUM_CMP; l++) begin
            set_m = set_m | set_all[l];
            clr_m = clr_m | clr_all[l];
            dup   = dup | (seen & norm_a_all[l]);
            seen  = seen | norm_a_all[l];
            dup   = dup | (seen & norm_b_all[l]);
            seen  = seen | norm_b_all[l];
        end
        clash = |dup;
    end

endmodule

// File: rtl/pred_regs.sv
// Predicate storage and the registered clash flag.
module pred_regs #(
    parameter int NUM_PREDS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PREDS-1:0] set_m,
    input  logic [NUM_PREDS-1:0] clr_m,
    input  logic                 clash,
    output logic [NUM_PREDS-1:0] bits,
    output logic                 err
);

    typedef struct packed {
        logic [NUM_PREDS-1:0] bits;
        logic                 err;
    } st_t;

    localparam logic [NUM_PREDS-1:0] RST_BITS = NUM_PREDS'(1);

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d         = st_q;
        // clear has priority over set within one group
        st_d.bits    = (st_q.bits | set_m) & ~clr_m;
        st_d.bits[0] = 1'b1;
        st_d.err     = clash;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= RST_BITS;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;
    assign err  = st_q.err;

endmodule

// File: rtl/pred_file.sv
module pred_file #(
    parameter int NUM_PREDS = 64,
    parameter int NUM_CMP   = 4,
    parameter int NUM_RD    = 2,
    localparam int IDX_W    = $clog2(NUM_PREDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CMP-1:0]         cmp_vld,
    input  logic [NUM_CMP*IDX_W-1:0]   cmp_qp,
    input  logic [NUM_CMP*IDX_W-1:0]   cmp_dst_a,
    input  logic [NUM_CMP*IDX_W-1:0]   cmp_dst_b,
    input  logic [NUM_CMP*2-1:0]       cmp_kind,
    input  logic [NUM_CMP-1:0]         cmp_cond,
    input  logic [NUM_CMP-1:0]         cmp_tag,
    input  logic [NUM_RD*IDX_W-1:0]    rd_idx,
    output logic [NUM_RD-1:0]          rd_val,
    output logic                       conflict_err
);

    logic [NUM_PREDS-1:0]              pred_bits;
    logic [NUM_CMP-1:0][NUM_PREDS-1:0] set_all;
    logic [NUM_CMP-1:0][NUM_PREDS-1:0] clr_all;
    logic [NUM_CMP-1:0][NUM_PREDS-1:0] norm_a_all;
    logic [NUM_CMP-1:0][NUM_PREDS-1:0] norm_b_all;
    logic [NUM_PREDS-1:0]              set_m;
    logic [NUM_PREDS-1:0]              clr_m;
    logic                              clash;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_lane
        logic qp_true;
        // qualifier comes from the state before this group (R8)
        assign qp_true = pred_bits[cmp_qp[g*IDX_W +: IDX_W]];

        pred_cmp_lane #(
            .NUM_PREDS (NUM_PREDS),
            .IDX_W     (IDX_W)
        ) u_lane (
            .vld      (cmp_vld[g]),
            .qp_true  (qp_true),
            .dst_a    (cmp_dst_a[g*IDX_W +: IDX_W]),
            .dst_b    (cmp_dst_b[g*IDX_W +: IDX_W]),
            .kind     (cmp_kind[g*2 +: 2]),
            .cond     (cmp_cond[g]),
            .tag      (cmp_tag[g]),
            .set_m    (set_all[g]),
            .clr_m    (clr_all[g]),
            .norm_a_m (norm_a_all[g]),
            .norm_b_m (norm_b_all[g])
        );
    end

    pred_merge #(
        .NUM_CMP   (NUM_CMP),
        .NUM_PREDS (NUM_PREDS)
    ) u_merge (
        .set_all    (set_all),
        .clr_all    (clr_all),
        .norm_a_all (norm_a_all),
        .norm_b_all (norm_b_all),
        .set_m      (set_m),
        .clr_m      (clr_m),
        .clash      (clash)
    );

    pred_regs #(
        .NUM_PREDS (NUM_PREDS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (set_m),
        .clr_m (clr_m),
        .clash (clash),
        .bits  (pred_bits),
        .err   (conflict_err)
    );

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rd_val[r] = pred_bits[rd_idx[r*IDX_W +: IDX_W]];
    end

endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk
    import pred_pkg::*;
#(
    parameter int NUM_PREDS = 64,
    parameter int NUM_CMP   = 4,
    parameter int NUM_RD    = 2,
    parameter int IDX_W     = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CMP-1:0]       cmp_vld,
    input logic [NUM_CMP*IDX_W-1:0] cmp_qp,
    input logic [NUM_CMP*IDX_W-1:0] cmp_dst_a,
    input logic [NUM_CMP*2-1:0]     cmp_kind,
    input logic [NUM_CMP-1:0]       cmp_tag,
    input logic [NUM_RD*IDX_W-1:0]  rd_idx,
    input logic [NUM_RD-1:0]        rd_val,
    input logic [NUM_PREDS-1:0]     pred_bits,
    input logic                     conflict_err
);

    logic [NUM_CMP-1:0] qual;
    logic               no_eff;
    logic               no_rise;
    logic               no_fall;
    logic               pair_clash;

    always_comb begin
        no_eff  = 1'b1;
        no_rise = 1'b1;
        no_fall = 1'b1;
        for (int l = 0; l < NUM_CMP; l++) begin
            qual[l] = cmp_vld[l] && pred_bits[cmp_qp[l*IDX_W +: IDX_W]]
                      && (cmp_kind[l*2 +: 2] != 2'd3);
            if (qual[l]) begin
                no_eff = 1'b0;
                if (!(cmp_kind[l*2 +: 2] == 2'd1 || cmp_tag[l])) no_rise = 1'b0;
                if (!(cmp_kind[l*2 +: 2] == 2'd2 && !cmp_tag[l])) no_fall = 1'b0;
            end
        end
        pair_clash = qual[0] && qual[1] && (cmp_kind[1:0] == 2'd0)
                     && (cmp_kind[3:2] == 2'd0)
                     && (cmp_dst_a[IDX_W-1:0] == cmp_dst_a[2*IDX_W-1:IDX_W])
                     && (cmp_dst_a[IDX_W-1:0] != '0);
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd_chk
        // R1
        p0_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx[r*IDX_W +: IDX_W] == '0) |-> rd_val[r]);
    end

    // R3
    squash_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_eff |=> (pred_bits == $past(pred_bits)));

    // R4
    and_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_rise |=> ((pred_bits & ~$past(pred_bits)) == '0));

    // R5
    or_never_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_fall |=> ((~pred_bits & $past(pred_bits)) == '0));

    // R9
    normal_clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_clash |=> conflict_err);

endmodule

bind pred_file pred_file_chk #(
    .NUM_PREDS (NUM_PREDS),
    .NUM_CMP   (NUM_CMP),
    .NUM_RD    (NUM_RD),
    .IDX_W     (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_vld      (cmp_vld),
    .cmp_qp       (cmp_qp),
    .cmp_dst_a    (cmp_dst_a),
    .cmp_kind     (cmp_kind),
    .cmp_tag      (cmp_tag),
    .rd_idx       (rd_idx),
    .rd_val       (rd_val),
    .pred_bits    (pred_bits),
    .conflict_err (conflict_err)
);

// File: tb/pred_file_tb.sv
`timescale 1ns/1ps
module pred_file_tb;

    localparam int NP = 64;
    localparam int NC = 4;
    localparam int NR = 2;
    localparam int IW = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    cmp_vld = '0;
    logic [NC*IW-1:0] cmp_qp = '0;
    logic [NC*IW-1:0] cmp_dst_a = '0;
    logic [NC*IW-1:0] cmp_dst_b = '0;
    logic [NC*2-1:0]  cmp_kind = '0;
    logic [NC-1:0]    cmp_cond = '0;
    logic [NC-1:0]    cmp_tag = '0;
    logic [NR*IW-1:0] rd_idx = '0;
    logic [NR-1:0]    rd_val;
    logic             conflict_err;

    always #5 clk = ~clk;

    pred_file u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_vld      (cmp_vld),
        .cmp_qp       (cmp_qp),
        .cmp_dst_a    (cmp_dst_a),
        .cmp_dst_b    (cmp_dst_b),
        .cmp_kind     (cmp_kind),
        .cmp_cond     (cmp_cond),
        .cmp_tag      (cmp_tag),
        .rd_idx       (rd_idx),
        .rd_val       (rd_val),
        .conflict_err (conflict_err)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  err;
        string rq;
    } exp_t;
    exp_t sb_q[$];

    // reference predicate state
    logic [NP-1:0] ref_p;

    // lane stimulus staging
    logic       l_vld  [NC];
    int         l_qp   [NC];
    int         l_a    [NC];
    int         l_b    [NC];
    int         l_kind [NC];
    logic       l_cond [NC];
    logic       l_tag  [NC];

    task automatic clear_lanes();
        for (int l = 0; l < NC; l++) begin
            l_vld[l] = 1'b0; l_qp[l] = 0; l_a[l] = 0; l_b[l] = 0;
            l_kind[l] = 0; l_cond[l] = 1'b0; l_tag[l] = 1'b0;
        end
    endtask

    task automatic set_lane(int l, int qp, int a, int b, int kind, logic cond, logic tag);
        l_vld[l] = 1'b1; l_qp[l] = qp; l_a[l] = a; l_b[l] = b;
        l_kind[l] = kind; l_cond[l] = cond; l_tag[l] = tag;
    endtask

    // driver: model the group from the requirements, push expectation, drive
    task automatic fire(string rq);
        logic [NP-1:0] setm, clrm;
        int            nwr [NP];
        logic          exp_err;
        exp_t          e;
        setm = '0; clrm = '0; exp_err = 1'b0;
        for (int i = 0; i < NP; i++) nwr[i] = 0;
        for (int l = 0; l < NC; l++) begin
            if (l_vld[l] && ref_p[l_qp[l]] && l_kind[l] != 3) begin
                if (l_kind[l] == 0) begin
                    nwr[l_a[l]]++;
                    nwr[l_b[l]]++;
                end
                if (l_tag[l]) begin
                    clrm[l_a[l]] = 1'b1; clrm[l_b[l]] = 1'b1;
                end else if (l_kind[l] == 0) begin
                    if (l_cond[l]) begin setm[l_a[l]] = 1'b1; clrm[l_b[l]] = 1'b1; end
                    else           begin clrm[l_a[l]] = 1'b1; setm[l_b[l]] = 1'b1; end
                end else if (l_kind[l] == 1) begin
                    if (!l_cond[l]) begin clrm[l_a[l]] = 1'b1; clrm[l_b[l]] = 1'b1; end
                end else if (l_kind[l] == 2) begin
                    if (l_cond[l]) begin setm[l_a[l]] = 1'b1; setm[l_b[l]] = 1'b1; end
                end
            end
        end
        for (int i = 1; i < NP; i++) if (nwr[i] > 1) exp_err = 1'b1;
        @(negedge clk);
        for (int l = 0; l < NC; l++) begin
            cmp_vld[l]              = l_vld[l];
            cmp_qp[l*IW +: IW]      = IW'(l_qp[l]);
            cmp_dst_a[l*IW +: IW]   = IW'(l_a[l]);
            cmp_dst_b[l*IW +: IW]   = IW'(l_b[l]);
            cmp_kind[l*2 +: 2]      = 2'(l_kind[l]);
            cmp_cond[l]             = l_cond[l];
            cmp_tag[l]              = l_tag[l];
        end
        e.err = exp_err; e.rq = rq;
        sb_q.push_back(e);
        @(posedge clk);
        ref_p    = (ref_p | setm) & ~clrm;
        ref_p[0] = 1'b1;
        @(negedge clk);
        cmp_vld = '0;
        clear_lanes();
    endtask

    // monitor: conflict flag one cycle after each group
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (conflict_err !== e.err) begin
                    errors++;
                    $display("FAIL %s conflict_err got=%0b exp=%0b", e.rq, conflict_err, e.err);
                end
            end
        end
    end

    // sweep all predicates through both read ports (R10)
    task automatic check_all(string rq);
        for (int i = 0; i < NP/2; i++) begin
            @(negedge clk);
            rd_idx[0 +: IW]  = IW'(i);
            rd_idx[IW +: IW] = IW'(i + NP/2);
            #2;
            checks += 2;
            if (rd_val[0] !== ref_p[i]) begin
                errors++;
                $display("FAIL %s p%0d got=%0b exp=%0b", rq, i, rd_val[0], ref_p[i]);
            end
            if (rd_val[1] !== ref_p[i + NP/2]) begin
                errors++;
                $display("FAIL %s p%0d got=%0b exp=%0b", rq, i + NP/2, rd_val[1], ref_p[i + NP/2]);
            end
        end
    endtask

    initial begin
        ref_p = NP'(1);
        clear_lanes();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (conflict_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 conflict_err after reset got=%0b exp=0", conflict_err);
        end
        check_all("R1_reset");

        // R2: normal compares, both condition polarities
        set_lane(0, 0, 5, 6, 0, 1'b1, 1'b0);
        set_lane(1, 0, 7, 8, 0, 1'b0, 1'b0);
        fire("R2");
        check_all("R2_normal");

        // R3: qualifier p9 is 0, so every lane is squashed
        set_lane(0, 9, 5, 6, 0, 1'b0, 1'b0);
        set_lane(1, 9, 8, 7, 1, 1'b0, 1'b0);
        set_lane(2, 9, 20, 21, 2, 1'b1, 1'b0);
        set_lane(3, 9, 5, 22, 0, 1'b1, 1'b1);
        fire("R3");
        check_all("R3_squash");

        // R5: or-kind sets on any true condition, false is a no-op
        set_lane(0, 0, 10, 11, 2, 1'b0, 1'b0);
        set_lane(1, 0, 10, 11, 2, 1'b1, 1'b0);
        set_lane(2, 0, 10, 11, 2, 1'b0, 1'b0);
        set_lane(3, 0, 12, 13, 2, 1'b0, 1'b0);
        fire("R5");
        check_all("R5_or");

        // R4: and-kind all true keeps, any false clears
        set_lane(0, 0, 10, 11, 1, 1'b1, 1'b0);
        set_lane(1, 0, 10, 11, 1, 1'b1, 1'b0);
        fire("R4");
        check_all("R4_and_true");
        set_lane(0, 5, 10, 11, 1, 1'b1, 1'b0);
        set_lane(1, 5, 10, 11, 1, 1'b0, 1'b0);
        set_lane(2, 5, 10, 11, 1, 1'b1, 1'b0);
        fire("R4");
        check_all("R4_and_false");

        // R6: tagged sources force false for every kind
        set_lane(0, 0, 22, 21, 0, 1'b0, 1'b0);
        fire("R6");
        set_lane(0, 0, 8, 13, 2, 1'b1, 1'b1);
        set_lane(1, 0, 21, 22, 0, 1'b1, 1'b1);
        set_lane(2, 0, 5, 5, 1, 1'b1, 1'b1);
        fire("R6");
        check_all("R6_tag");

        // R10: kind 3 writes nothing, even tagged
        set_lane(0, 0, 7, 8, 3, 1'b1, 1'b1);
        set_lane(1, 0, 23, 24, 3, 1'b1, 1'b0);
        fire("R10");
        check_all("R10_kind3");

        // R7: writes to predicate 0 ignored
        set_lane(0, 0, 0, 30, 0, 1'b0, 1'b0);
        set_lane(1, 0, 31, 0, 1, 1'b0, 1'b0);
        fire("R7");
        check_all("R7_p0");

        // R8: qualifier sampled before the group; clear beats set
        set_lane(0, 0, 40, 41, 0, 1'b1, 1'b0);
        set_lane(1, 40, 42, 43, 0, 1'b1, 1'b0);
        set_lane(2, 0, 44, 44, 2, 1'b1, 1'b0);
        set_lane(3, 0, 44, 45, 1, 1'b0, 1'b0);
        fire("R8");
        check_all("R8_group");
        set_lane(0, 40, 42, 46, 0, 1'b1, 1'b0);
        fire("R8");
        check_all("R8_qual_next");

        // R9: clashing normal writes
        set_lane(0, 0, 50, 51, 0, 1'b1, 1'b0);
        set_lane(1, 0, 50, 52, 0, 1'b1, 1'b0);
        fire("R9");
        check_all("R9_two_lanes");
        set_lane(0, 0, 53, 53, 0, 1'b1, 1'b0);
        fire("R9");
        check_all("R9_same_lane");
        // parallel kinds sharing a target do not clash; flag drops again
        set_lane(0, 0, 54, 55, 2, 1'b1, 1'b0);
        set_lane(1, 0, 54, 55, 2, 1'b1, 1'b0);
        set_lane(2, 0, 56, 57, 0, 1'b1, 1'b0);
        fire("R9");
        check_all("R9_no_clash");
        fire("R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule